// File: doc/BRIEF.md
# Programmable parallel port controller

This peripheral gives a host processor three 8-bit parallel ports (A, B and C) behind an 8-bit data bus. The host selects one of four locations with a two-bit address, and uses active-low chip select, read and write strobes. Three locations hold the port data. The fourth takes command words and returns the current configuration. Port C is treated as two independent nibbles. The upper nibble belongs with port A and the lower nibble with port B when port direction is chosen.

A command word with bit 7 high sets the direction and mode of every port group. A command word with bit 7 low sets or clears a single port C pin without disturbing any other state. Only plain latched I/O is carried out. The handshake mode fields are stored and can be read back, but they change nothing on the pins. Bidirectional pins appear as separate input, output and output-enable buses. Host writes pass through a synchronizer into the internal clock domain and take effect after the write strobe has risen.

Top module: `pport_ctrl`

## Requirements
- R1: Address 2'b00 selects port A, 2'b01 port B, 2'b10 port C and 2'b11 the control location, for both reads and writes. A port data write loads that port's output latch.
- R2: While rst_ni is low and after it returns high, every output latch is zero, every output enable is low (all ports input) and the control location reads 8'h9B.
- R3: A write takes effect only when wr_ni rises while cs_ni is low. The rise is seen after the bus has been synchronized to clk_i. A strobe with cs_ni high changes nothing.
- R4: A control write with bit 7 = 1 sets directions. Bit 4 is port A, bit 3 is upper port C, bit 1 is port B and bit 0 is lower port C. A 1 means input, and an output port drives its output enables high.
- R5: A configuration write (bit 7 = 1) clears the output latches of ports A, B and C.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C pin numbered by bits 3..1. Bits 6..4 are ignored. Every other port C pin and every direction stays unchanged.
- R7: A read of an input port returns its live pins, and a read of an output port returns its latch. Port C is resolved per nibble.
- R8: A read of the control location returns the last configuration word. Bit-set/reset writes do not alter it.
- R9: data_oe_o is high exactly while cs_ni and rd_ni are both low.
- R10: The mode fields (bits 6..5 for group A, bit 2 for group B) are stored and read back but do not change port behaviour.
- R11: Configuration word 8'h92 makes ports A and B inputs and both halves of port C outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Location select |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Host bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-pin drive enable |

## Verification
The hardest case to reach is a port C read with its two nibbles pointing in opposite directions. In that case one half of the returned byte must come from the pins and the other half from the latch. It takes a configuration write with mixed direction bits, then a data write that sets every latch bit, on pins held to a pattern that differs per nibble. Bit-set/reset sequences are also chained with the ignored bits 6..4 set high. This shows that each pin changes alone and that the stored configuration word survives.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // bit layout follows the command word
  typedef struct packed {
    logic       is_cfg;
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = 8'h9B;
endpackage

// File: rtl/pport_sync.sv
module pport_sync
  import pport_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PORT_W-1:0] data_o
);
  localparam int BW = 2 + ADDR_W + PORT_W;
  localparam logic [BW-1:0] IDLE = {2'b11, {(ADDR_W+PORT_W){1'b0}}};

  logic [BW-1:0] stage_q [STAGES];
  logic [BW-1:0] last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= IDLE;
        else         stage_q[i] <= {cs_ni, wr_ni, addr_i, data_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= IDLE;
        else         stage_q[i] <= stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= IDLE;
    else         last_q <= stage_q[STAGES-1];

  logic cur_wr_n, last_wr_n, last_cs_n;
  assign cur_wr_n  = stage_q[STAGES-1][BW-2];
  assign last_cs_n = last_q[BW-1];
  assign last_wr_n = last_q[BW-2];

  // rising strobe; address and data taken from the last low-strobe sample
  assign fire_o = cur_wr_n & ~last_wr_n & ~last_cs_n;
  assign addr_o = last_q[PORT_W +: ADDR_W];
  assign data_o = last_q[PORT_W-1:0];
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output cfg_t              cfg_o,
  output logic [PORT_W-1:0] pa_q_o,
  output logic [PORT_W-1:0] pb_q_o,
  output logic [PORT_W-1:0] pc_q_o
);
  localparam int PIN_W = $clog2(PORT_W);

  sel_e sel;
  logic cmd_cfg, cmd_bit;
  logic [PIN_W-1:0] pin_sel;

  assign sel     = sel_e'(addr_i);
  assign cmd_cfg = fire_i && sel == SEL_CTRL &&  data_i[PORT_W-1];
  assign cmd_bit = fire_i && sel == SEL_CTRL && !data_i[PORT_W-1];
  assign pin_sel = data_i[PIN_W:1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cfg_o <= CFG_RST;
    else if (cmd_cfg) cfg_o <= cfg_t'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pa_q_o <= '0;
      pb_q_o <= '0;
    end else if (cmd_cfg) begin
      pa_q_o <= '0;
      pb_q_o <= '0;
    end else if (fire_i) begin
      if (sel == SEL_A) pa_q_o <= data_i;
      if (sel == SEL_B) pb_q_o <= data_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        pc_q_o <= '0;
    else if (cmd_cfg)                   pc_q_o <= '0;
    else if (cmd_bit)                   pc_q_o[pin_sel] <= data_i[0];
    else if (fire_i && sel == SEL_C)    pc_q_o <= data_i;
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
(
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_t              cfg_i,
  input  logic [PORT_W-1:0] pa_q_i,
  input  logic [PORT_W-1:0] pb_q_i,
  input  logic [PORT_W-1:0] pc_q_i,
  input  logic [PORT_W-1:0] pa_i,
  input  logic [PORT_W-1:0] pb_i,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int HALF = PORT_W / 2;

  logic [PORT_W-1:0] pa_rd, pb_rd, pc_rd;
  logic [1:0]        pc_half_in;

  assign pc_half_in = {cfg_i.cu_in, cfg_i.cl_in};
  assign pa_rd = cfg_i.a_in ? pa_i : pa_q_i;
  assign pb_rd = cfg_i.b_in ? pb_i : pb_q_i;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign pc_rd[h*HALF +: HALF] = pc_half_in[h] ? pc_i[h*HALF +: HALF]
                                                 : pc_q_i[h*HALF +: HALF];
  end

  always_comb begin
    unique case (sel_e'(addr_i))
      SEL_A:    data_o = pa_rd;
      SEL_B:    data_o = pb_rd;
      SEL_C:    data_o = pc_rd;
      default:  data_o = cfg_i;
    endcase
  end

  assign data_oe_o = ~cs_ni & ~rd_ni;
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic              pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic              pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int HALF = PORT_W / 2;

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [PORT_W-1:0] wr_data;
  cfg_t              cfg;

  pport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .wr_ni  (wr_ni),
    .addr_i (addr_i),
    .data_i (data_i),
    .fire_o (wr_fire),
    .addr_o (wr_addr),
    .data_o (wr_data)
  );

  pport_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_fire),
    .addr_i (wr_addr),
    .data_i (wr_data),
    .cfg_o  (cfg),
    .pa_q_o (pa_o),
    .pb_q_o (pb_o),
    .pc_q_o (pc_o)
  );

  pport_rdmux u_rdmux (
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .addr_i    (addr_i),
    .cfg_i     (cfg),
    .pa_q_i    (pa_o),
    .pb_q_i    (pb_o),
    .pc_q_i    (pc_o),
    .pa_i      (pa_i),
    .pb_i      (pb_i),
    .pc_i      (pc_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign pa_oe_o = ~cfg.a_in;
  assign pb_oe_o = ~cfg.b_in;
  assign pc_oe_o = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
endmodule

// File: rtl/pport_chk.sv
module pport_chk
  import pport_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] pa_o,
  input logic [PORT_W-1:0] pb_o,
  input logic [PORT_W-1:0] pc_o,
  input logic              pa_oe_o,
  input logic              pb_oe_o,
  input logic [PORT_W-1:0] pc_oe_o
);
  logic is_cfg, is_bit;
  assign is_cfg = wr_fire && wr_addr == 2'b11 &&  wr_data[7];
  assign is_bit = wr_fire && wr_addr == 2'b11 && !wr_data[7];

  assert_write_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && wr_addr == 2'b00 |=> pa_o == $past(wr_data));

  assert_write_b_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && wr_addr == 2'b01 |=> pb_o == $past(wr_data));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fire |=> $stable({pa_o, pb_o, pc_o, pa_oe_o, pb_oe_o, pc_oe_o}));

  assert_cfg_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cfg |=> pa_oe_o == !$past(wr_data[4]) && pb_oe_o == !$past(wr_data[1])
            && pc_oe_o == {{4{!$past(wr_data[3])}}, {4{!$past(wr_data[0])}}});

  assert_cfg_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cfg |=> pa_o == '0 && pb_o == '0 && pc_o == '0);

  assert_bit_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bit |=> pc_o[$past(wr_data[3:1])] == $past(wr_data[0]));

  assert_bit_others_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bit |=> ((pc_o ^ $past(pc_o)) & ~(8'd1 << $past(wr_data[3:1]))) == '0
            && $stable({pa_o, pb_o, pa_oe_o, pb_oe_o, pc_oe_o}));
endmodule

bind pport_ctrl pport_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_fire (wr_fire),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .pa_o    (pa_o),
  .pb_o    (pb_o),
  .pc_o    (pc_o),
  .pa_oe_o (pa_oe_o),
  .pb_oe_o (pb_oe_o),
  .pc_oe_o (pc_oe_o)
);

// File: tb/pport_ctrl_test.sv
`timescale 1ns/1ps
module pport_ctrl_test;
  logic       clk_i = 0, rst_ni = 0;
  logic       cs_ni = 1, rd_ni = 1, wr_ni = 1;
  logic [1:0] addr_i = 0;
  logic [7:0] data_i = 0;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic [7:0] pa_i = 8'h5A, pb_i = 8'hC3, pc_i = 8'h3C;
  logic [7:0] pa_o, pb_o, pc_o, pc_oe_o;
  logic       pa_oe_o, pb_oe_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pport_ctrl uut (.*);

  // {req[7:0], kind[1:0] (0 write, 1 read), addr[1:0], wdata[7:0], expect[7:0]}
  localparam int N = 33;
  localparam logic [27:0] VEC [N] = '{
    {8'd8,  2'd1, 2'd3, 8'h00, 8'h9B},  // R8 reset config word
    {8'd7,  2'd1, 2'd0, 8'h00, 8'h5A},  // R7 input reads pins
    {8'd7,  2'd1, 2'd1, 8'h00, 8'hC3},
    {8'd7,  2'd1, 2'd2, 8'h00, 8'h3C},
    {8'd4,  2'd0, 2'd3, 8'h80, 8'h00},  // R4 all outputs
    {8'd5,  2'd1, 2'd0, 8'h00, 8'h00},  // R5
    {8'd1,  2'd0, 2'd0, 8'h11, 8'h00},  // R1 port A
    {8'd1,  2'd1, 2'd0, 8'h00, 8'h11},
    {8'd1,  2'd0, 2'd1, 8'h22, 8'h00},  // R1 port B
    {8'd1,  2'd1, 2'd1, 8'h00, 8'h22},
    {8'd1,  2'd0, 2'd2, 8'h33, 8'h00},  // R1 port C
    {8'd1,  2'd1, 2'd2, 8'h00, 8'h33},
    {8'd11, 2'd0, 2'd3, 8'h92, 8'h00},  // R11
    {8'd11, 2'd1, 2'd0, 8'h00, 8'h5A},
    {8'd11, 2'd1, 2'd1, 8'h00, 8'hC3},
    {8'd5,  2'd1, 2'd2, 8'h00, 8'h00},  // R5 latch cleared
    {8'd8,  2'd1, 2'd3, 8'h00, 8'h92},
    {8'd6,  2'd0, 2'd3, 8'h07, 8'h00},  // R6 set pin 3
    {8'd6,  2'd1, 2'd2, 8'h00, 8'h08},
    {8'd6,  2'd0, 2'd3, 8'h7F, 8'h00},  // R6 set pin 7, bits 6..4 high
    {8'd6,  2'd1, 2'd2, 8'h00, 8'h88},
    {8'd6,  2'd0, 2'd3, 8'h06, 8'h00},  // R6 clear pin 3
    {8'd6,  2'd1, 2'd2, 8'h00, 8'h80},
    {8'd8,  2'd1, 2'd3, 8'h00, 8'h92},  // R8 unchanged by bit commands
    {8'd7,  2'd0, 2'd3, 8'h88, 8'h00},  // R7 upper C in, lower C out
    {8'd7,  2'd0, 2'd2, 8'hFF, 8'h00},
    {8'd7,  2'd1, 2'd2, 8'h00, 8'h3F},
    {8'd10, 2'd0, 2'd3, 8'hE4, 8'h00},  // R10 odd modes, all outputs
    {8'd10, 2'd0, 2'd0, 8'h05, 8'h00},
    {8'd10, 2'd1, 2'd0, 8'h00, 8'h05},
    {8'd10, 2'd1, 2'd3, 8'h00, 8'hE4},
    {8'd10, 2'd1, 2'd1, 8'h00, 8'h00},
    {8'd10, 2'd1, 2'd2, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk_i);
    addr_i = a; data_i = d; cs_ni = !sel; wr_ni = 0;
    repeat (2) @(negedge clk_i);
    wr_ni = 1;
    @(negedge clk_i);
    cs_ni = 1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; cs_ni = 0; rd_ni = 0;
    #1 d = data_o;
    @(negedge clk_i);
    cs_ni = 1; rd_ni = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk_i);
    // R2 state while reset held
    chk("R2 pa_o in reset", pa_o, 8'h00);
    chk("R2 oe in reset", {6'd0, pa_oe_o, pb_oe_o}, 8'h00);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk("R2 pc_oe after reset", pc_oe_o, 8'h00);
    chk("R9 idle bus drive", {7'd0, data_oe_o}, 8'h00);

    for (int i = 0; i < N; i++) begin
      if (VEC[i][19:18] == 2'd0) bus_write(VEC[i][17:16], VEC[i][15:8], 1);
      else begin
        bus_read(VEC[i][17:16], rd);
        chk($sformatf("R%0d vector %0d", VEC[i][27:20], i), rd, VEC[i][7:0]);
      end
    end

    // R10 modes leave port A driving as plain output
    chk("R10 pa_oe under mode bits", {7'd0, pa_oe_o}, 8'h01);

    // R4 / R11 direction outputs
    bus_write(2'd3, 8'h92, 1);
    chk("R11 A/B enables", {6'd0, pa_oe_o, pb_oe_o}, 8'h00);
    chk("R4 pc enables", pc_oe_o, 8'hFF);
    bus_write(2'd3, 8'h8A, 1);
    chk("R4 mixed enables", {pa_oe_o, pb_oe_o, 6'd0}, 8'h80);
    chk("R4 mixed pc", pc_oe_o, 8'h0F);

    // R3 strobe without chip select
    bus_write(2'd3, 8'h80, 1);
    bus_write(2'd0, 8'h44, 1);
    bus_write(2'd0, 8'h99, 0);
    chk("R3 ignored write pa_o", pa_o, 8'h44);
    bus_read(2'd0, rd);
    chk("R3 ignored write read", rd, 8'h44);

    // R6 bit command keeps directions and other latches
    bus_write(2'd3, 8'h0F, 1);
    chk("R6 pc after set", pc_o, 8'h80);
    chk("R6 directions kept", {pa_oe_o, pb_oe_o, 6'd0}, 8'hC0);
    chk("R6 pa kept", pa_o, 8'h44);
    bus_read(2'd3, rd);
    chk("R8 config after bit cmd", rd, 8'h80);

    // R9 drive during read
    @(negedge clk_i);
    addr_i = 2'd1; cs_ni = 0; rd_ni = 0;
    #1 chk("R9 drive on read", {7'd0, data_oe_o}, 8'h01);
    rd_ni = 1;
    #1 chk("R9 release", {7'd0, data_oe_o}, 8'h00);
    cs_ni = 1;

    // R2 reset in mid-run
    @(negedge clk_i);
    rst_ni = 0;
    #1 chk("R2 mid reset pc_o", pc_o, 8'h00);
    chk("R2 mid reset pa_oe", {7'd0, pa_oe_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1;
    bus_read(2'd3, rd);
    chk("R2 mid reset config", rd, 8'h9B);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule